// File: doc/BRIEF.md
# Shift-and-Saturate Execution Unit

This unit is one execution slot of a 32-bit processor datapath. Each cycle it can take an instruction word, the value already read for its source operand, the current N/Z/C/V flags and a valid strobe. From the instruction it pulls out a condition code, a destination register index, a shift kind, a shift distance and a saturation width. The operand is shifted first. The shifted value is then clamped to a signed range or an unsigned range, and the `sat_unsigned` input picks which one. Both modes share the same decode and shift hardware.

One clock after the valid strobe, the unit presents the clamped result, the destination index, a register write enable and a one-cycle pulse that reports whether clamping took place. It also keeps a sticky saturation status bit. Clamping sets that bit, and only reset clears it. When an instruction's condition does not hold, the instruction still retires with a valid output, but it writes no register and changes no status.

Top module: `shsat_unit`

## Requirements
- R1: The instruction fields are fixed: condition in bits 31:28, saturation width n in bits 20:16, destination index in bits 15:12, shift distance in bits 11:7, shift kind in bit 6. `out_dest` carries bits 15:12 of the accepted instruction.
- R2: Shift kind 0 shifts the operand left by the shift distance (0..31), and bits shifted past bit 31 are lost.
- R3: Shift kind 1 shifts the operand right arithmetically by the shift distance. A distance of 0 with this kind shifts by 31 instead.
- R4: In signed mode (`sat_unsigned`=0), a shifted value above 2^n-1 yields 2^n-1, and a value below -2^n yields -2^n. Any other value passes unchanged.
- R5: In unsigned mode (`sat_unsigned`=1), a negative shifted value yields 0, and a value above 2^n-1 yields 2^n-1. Any other value passes unchanged.
- R6: When an executed instruction clamps, `out_sat_hit` pulses high with its result and `sat_sticky` becomes 1. Nothing except reset ever returns `sat_sticky` to 0.
- R7: Condition 0xE always executes. Using flags N=`nzcv[3]`, Z=`nzcv[2]`, C=`nzcv[1]`, V=`nzcv[0]`, the other codes execute when the following holds: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V). Code 0xF never executes.
- R8: An instruction whose condition fails gives `out_valid`=1 with `out_wen`=0 and `out_sat_hit`=0, and it leaves `sat_sticky` unchanged.
- R9: The registered outputs appear on the first rising edge after `in_valid` is sampled. `out_valid` equals `in_valid` delayed by one cycle, and `out_wen` is never high without `out_valid`.
- R10: A synchronous active-low reset clears `out_valid`, `out_wen`, `out_sat_hit` and `sat_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| operand | input | 32 | Source operand value |
| nzcv | input | 4 | Current flags N,Z,C,V (bit 3 down to bit 0) |
| sat_unsigned | input | 1 | 1 selects unsigned clamping, 0 selects signed |
| out_valid | output | 1 | Retired instruction present |
| out_result | output | 32 | Clamped result |
| out_dest | output | 4 | Destination register index |
| out_wen | output | 1 | Write the result to the destination |
| out_sat_hit | output | 1 | Pulse: this executed instruction clamped |
| sat_sticky | output | 1 | Sticky saturation status bit |

## Verification
Clamping and condition failure can fall in the same instruction: the operand would saturate, but the flags veto execution. The bench forces this case directly, with a saturating operand under a failing condition while the sticky bit is still clear. It then judges that case at the ports through `out_wen`, `out_sat_hit` and `sat_sticky`. The random stream mixes all sixteen condition codes with small widths and large shifts, so the overlap comes up again many times, and each time a reference model decides the expected write and status behaviour.

// File: rtl/shsat_pkg.sv
// Shared types for the shift-and-saturate unit.
// Assumes the fixed 32-bit instruction field layout that the decoder relies on.
package shsat_pkg;

    typedef enum logic {
        SHK_LSL = 1'b0,
        SHK_ASR = 1'b1
    } shift_kind_e;

    typedef struct packed {
        logic [3:0]  cond;
        logic [4:0]  width;
        logic [3:0]  dest;
        logic [4:0]  amount;
        shift_kind_e kind;
    } sat_op_t;

    localparam logic [3:0] COND_ALWAYS = 4'hE;

    // Evaluates a 4-bit condition code against flags {N,Z,C,V}.
    function automatic logic cond_holds(input logic [3:0] cond, input logic [3:0] flags);
        logic n, z, c, v;
        logic res;
        n = flags[3];
        z = flags[2];
        c = flags[1];
        v = flags[0];
        case (cond)
            4'h0:    res = z;
            4'h1:    res = !z;
            4'h2:    res = c;
            4'h3:    res = !c;
            4'h4:    res = n;
            4'h5:    res = !n;
            4'h6:    res = v;
            4'h7:    res = !v;
            4'h8:    res = c && !z;
            4'h9:    res = !c || z;
            4'hA:    res = (n == v);
            4'hB:    res = (n != v);
            4'hC:    res = !z && (n == v);
            4'hD:    res = z || (n != v);
            4'hE:    res = 1'b1;
            default: res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/shsat_decode.sv
// Field decoder and condition check.
// Splits the instruction word into the operation fields and evaluates
// its condition against the current flags. Purely combinational.
module shsat_decode
    import shsat_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [3:0]  nzcv,
    output sat_op_t     op,
    output logic        cond_pass
);

    logic unused_instr_bits;

    // Pulls the fields out of their fixed bit positions.
    always_comb begin
        op.cond   = instr[31:28];
        op.width  = instr[20:16];
        op.dest   = instr[15:12];
        op.amount = instr[11:7];
        op.kind   = shift_kind_e'(instr[6]);
    end

    // Bits with no meaning to this unit.
    assign unused_instr_bits = ^{instr[27:21], instr[5:0]};

    // The condition gates execution.
    assign cond_pass = cond_holds(op.cond, nzcv);

endmodule

// File: rtl/shsat_shifter.sv
// Operand shifter ahead of the clamp.
// Left logical or right arithmetic. A right shift with distance 0
// stands for the widest shift, DATA_W-1. Combinational.
module shsat_shifter
    import shsat_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value_in,
    input  shift_kind_e       kind,
    input  logic [AMT_W-1:0]  amount,
    output logic [DATA_W-1:0] value_out
);

    localparam logic [AMT_W-1:0] WIDEST = AMT_W'(DATA_W - 1);

    logic [AMT_W-1:0] asr_amount;

    // A zero distance on a right shift is redefined as the widest shift.
    assign asr_amount = (amount == '0) ? WIDEST : amount;

    // Picks the shift direction.
    always_comb begin
        if (kind == SHK_LSL)
            value_out = value_in << amount;
        else
            value_out = DATA_W'($signed(value_in) >>> asr_amount);
    end

endmodule

// File: rtl/shsat_clamp.sv
// Range clamp with a width field n.
// SIGNED_MODE=1 keeps the value within [-2^n, 2^n-1]. SIGNED_MODE=0
// keeps it within [0, 2^n-1]. Reports whether the value was changed.
module shsat_clamp #(
    parameter int DATA_W      = 32,
    parameter bit SIGNED_MODE = 1'b1,
    localparam int WID_W      = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value_in,
    input  logic [WID_W-1:0]  width,
    output logic [DATA_W-1:0] value_out,
    output logic              clamped
);

    logic [DATA_W-1:0] upper;

    // Largest value allowed: n ones in the low bits.
    assign upper = ~({DATA_W{1'b1}} << width);

    generate
        if (SIGNED_MODE) begin : g_signed
            logic [DATA_W-1:0] top;
            logic              above;
            logic              below;

            // Bits above the n-bit magnitude must all match the sign.
            assign top   = DATA_W'($signed(value_in) >>> width);
            assign above = !top[DATA_W-1] && (|top);
            assign below = top[DATA_W-1] && !(&top);

            // Selects the limit or the value unchanged.
            always_comb begin
                clamped = above || below;
                if (above)
                    value_out = upper;
                else if (below)
                    value_out = ~upper;
                else
                    value_out = value_in;
            end
        end else begin : g_unsigned
            logic negative;
            logic over;

            assign negative = value_in[DATA_W-1];
            assign over     = !negative && (value_in > upper);

            // Floors negatives at zero and caps large values.
            always_comb begin
                clamped = negative || over;
                if (negative)
                    value_out = '0;
                else if (over)
                    value_out = upper;
                else
                    value_out = value_in;
            end
        end
    endgenerate

endmodule

// File: rtl/shsat_unit.sv
// Shift-and-saturate execution unit, top level.
// Decodes, shifts and clamps in a single cycle and registers the
// outputs, so results appear on the edge after in_valid.
// Assumes the operand is read elsewhere. Active-low synchronous reset.
module shsat_unit
    import shsat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] operand,
    input  logic [3:0]        nzcv,
    input  logic              sat_unsigned,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [IDX_W-1:0]  out_dest,
    output logic              out_wen,
    output logic              out_sat_hit,
    output logic              sat_sticky
);

    sat_op_t           op;
    logic              cond_pass;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] clamp_val [2];
    logic [1:0]        clamp_hit;
    logic [DATA_W-1:0] result_d;
    logic              hit_d;
    logic              exec_d;

    shsat_decode i_decode (
        .instr     (instr),
        .nzcv      (nzcv),
        .op        (op),
        .cond_pass (cond_pass)
    );

    shsat_shifter #(.DATA_W(DATA_W)) i_shifter (
        .value_in  (operand),
        .kind      (op.kind),
        .amount    (AMT_W'(op.amount)),
        .value_out (shifted)
    );

    // Index 0 is the unsigned clamp, index 1 the signed clamp.
    generate
        for (genvar g = 0; g < 2; g++) begin : g_clamp
            shsat_clamp #(.DATA_W(DATA_W), .SIGNED_MODE(g == 1)) i_clamp (
                .value_in  (shifted),
                .width     (AMT_W'(op.width)),
                .value_out (clamp_val[g]),
                .clamped   (clamp_hit[g])
            );
        end
    endgenerate

    // Picks the clamp flavour and qualifies execution.
    always_comb begin
        result_d = sat_unsigned ? clamp_val[0] : clamp_val[1];
        hit_d    = sat_unsigned ? clamp_hit[0] : clamp_hit[1];
        exec_d   = in_valid && cond_pass;
    end

    // The output valid tracks the input valid one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    // Write enable and clamp pulse come only from executed instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_wen     <= 1'b0;
            out_sat_hit <= 1'b0;
        end else begin
            out_wen     <= exec_d;
            out_sat_hit <= exec_d && hit_d;
        end
    end

    // Captures the result and destination of each accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            out_dest   <= '0;
        end else if (in_valid) begin
            out_result <= result_d;
            out_dest   <= IDX_W'(op.dest);
        end
    end

    // The status bit is set by clamping and cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sat_sticky <= 1'b0;
        else if (exec_d && hit_d)
            sat_sticky <= 1'b1;
    end

    // Assertions guarding the registered stage.
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid)
        else $error("out_valid missing after in_valid");

    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid)
        else $error("out_valid without in_valid");

    assert_wen_in_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> out_valid)
        else $error("out_wen without out_valid");

    assert_sticky_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sat_sticky |=> sat_sticky)
        else $error("sticky bit dropped");

    assert_hit_sets_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_sat_hit |-> (sat_sticky && out_wen))
        else $error("clamp pulse without sticky bit or write");

    assert_fail_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cond_pass) |=> (!out_wen && !out_sat_hit))
        else $error("write on failed condition");

    assert_always_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op.cond == COND_ALWAYS) |=> out_wen)
        else $error("always condition did not execute");

    assert_unsigned_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (clamp_val[0] <= ~({DATA_W{1'b1}} << op.width)))
        else $error("unsigned clamp above limit");

endmodule

// File: tb/test_shsat_unit.sv
module test_shsat_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] operand = '0;
    logic [3:0]  nzcv = '0;
    logic        sat_unsigned = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [3:0]  out_dest;
    logic        out_wen;
    logic        out_sat_hit;
    logic        sat_sticky;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit exp_sticky = 1'b0;

    always #2.5 clk = ~clk;

    shsat_unit i_shsat_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .operand(operand), .nzcv(nzcv), .sat_unsigned(sat_unsigned),
        .out_valid(out_valid), .out_result(out_result), .out_dest(out_dest),
        .out_wen(out_wen), .out_sat_hit(out_sat_hit), .sat_sticky(sat_sticky)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Condition truth from R7.
    function automatic bit ref_cond(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            0: return z;          1: return !z;
            2: return cy;         3: return !cy;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return cy && !z;   9: return !cy || z;
            10: return n == v;    11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Shift from R2/R3 and clamp from R4/R5, using wide arithmetic.
    function automatic void ref_model(input logic [31:0] ins, input logic [31:0] opv,
                                      input bit uns, output logic [31:0] res, output bit hit);
        int unsigned amt = ins[11:7];
        int unsigned w   = ins[20:16];
        logic [31:0] sh;
        longint val, hi, lo;
        if (ins[6] == 1'b0) sh = opv << amt;
        else sh = 32'($signed(opv) >>> ((amt == 0) ? 31 : amt));
        val = longint'($signed(sh));
        hi  = (longint'(1) << w) - 1;
        lo  = uns ? 0 : -(longint'(1) << w);
        hit = 1'b1;
        if (val > hi) res = 32'(hi);
        else if (val < lo) res = 32'(lo);
        else begin res = sh; hit = 1'b0; end
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] c, input logic [4:0] w,
                                       input logic [3:0] d, input logic [4:0] a, input bit k);
        return {c, 7'h15, w, d, a, k, 6'h2A};
    endfunction

    // Applies one instruction and checks the registered outputs after the edge.
    task automatic run(input logic [31:0] ins, input logic [31:0] opv,
                       input logic [3:0] f, input bit uns, input string tag);
        logic [31:0] er;
        bit eh, ep;
        @(negedge clk);
        in_valid = 1'b1; instr = ins; operand = opv; nzcv = f; sat_unsigned = uns;
        ref_model(ins, opv, uns, er, eh);
        ep = ref_cond(ins[31:28], f);
        @(posedge clk); #1;
        chk(out_valid == 1'b1, {tag, " R9 valid"}, 32'(out_valid), 1);
        chk(out_wen == ep, {tag, " R7/R8 wen"}, 32'(out_wen), 32'(ep));
        chk(out_dest == ins[15:12], {tag, " R1 dest"}, 32'(out_dest), 32'(ins[15:12]));
        chk(out_result == er, {tag, " R4/R5 result"}, out_result, er);
        chk(out_sat_hit == (ep && eh), {tag, " R6 pulse"}, 32'(out_sat_hit), 32'(ep && eh));
        if (ep && eh) exp_sticky = 1'b1;
        chk(sat_sticky == exp_sticky, {tag, " R6 sticky"}, 32'(sat_sticky), 32'(exp_sticky));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk(!out_valid && !out_wen && !out_sat_hit && !sat_sticky, "R10 reset state",
            {28'd0, out_valid, out_wen, out_sat_hit, sat_sticky}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R8: saturating operand under a failing condition (EQ with Z=0).
        run(mk(4'h0, 5'd3, 4'd5, 5'd0, 1'b0), 32'd1000, 4'b0000, 1'b0, "R8 fail+clamp");
        chk(sat_sticky == 1'b0, "R8 sticky unchanged", 32'(sat_sticky), 0);
        // R1/R2/R4: no shift, in range.
        run(mk(4'hE, 5'd7, 4'd9, 5'd0, 1'b0), 32'd100, 4'b0000, 1'b0, "R2 pass");
        // R2/R4: left shift into signed clamp, 0x7F<<1 -> 127.
        run(mk(4'hE, 5'd7, 4'd3, 5'd1, 1'b0), 32'h7F, 4'b0000, 1'b0, "R4 high");
        chk(out_result == 32'd127, "R4 high value", out_result, 32'd127);
        // R4: low clamp to -128.
        run(mk(4'hE, 5'd7, 4'd2, 5'd0, 1'b0), -32'sd500, 4'b0000, 1'b0, "R4 low");
        chk(out_result == 32'hFFFFFF80, "R4 low value", out_result, 32'hFFFFFF80);
        // R3: right shift distance 0 means 31.
        run(mk(4'hE, 5'd0, 4'd1, 5'd0, 1'b1), 32'h80000000, 4'b0000, 1'b0, "R3 asr31 neg");
        chk(out_result == 32'hFFFFFFFF, "R3 asr31 value", out_result, 32'hFFFFFFFF);
        run(mk(4'hE, 5'd0, 4'd1, 5'd0, 1'b1), 32'h7FFFFFFF, 4'b0000, 1'b0, "R3 asr31 pos");
        run(mk(4'hE, 5'd15, 4'd4, 5'd4, 1'b1), 32'hF0001230, 4'b0000, 1'b0, "R3 asr4");
        // R5: unsigned floor, cap and exact limit.
        run(mk(4'hE, 5'd8, 4'd6, 5'd0, 1'b0), -32'sd5, 4'b0000, 1'b1, "R5 neg");
        chk(out_result == 32'd0, "R5 neg value", out_result, 0);
        run(mk(4'hE, 5'd8, 4'd6, 5'd0, 1'b0), 32'd300, 4'b0000, 1'b1, "R5 over");
        run(mk(4'hE, 5'd8, 4'd6, 5'd0, 1'b0), 32'd255, 4'b0000, 1'b1, "R5 edge");
        run(mk(4'hE, 5'd31, 4'd7, 5'd0, 1'b0), 32'h80000001, 4'b0000, 1'b1, "R5 w31");
        // R7: each condition code with two flag patterns.
        for (int c = 0; c < 16; c++) begin
            run(mk(4'(c), 5'd4, 4'(c), 5'd2, 1'b0), 32'd3, 4'b0101, 1'b0, "R7 cond a");
            run(mk(4'(c), 5'd4, 4'(c), 5'd2, 1'b0), 32'd3, 4'b1010, 1'b0, "R7 cond b");
        end
        // R9: idle cycle yields no valid output.
        @(posedge clk); #1;
        chk(!out_valid && !out_wen, "R9 idle", {30'd0, out_valid, out_wen}, 0);
        // R10: reset mid-run clears the sticky bit.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk(!sat_sticky && !out_valid, "R10 mid reset", {30'd0, sat_sticky, out_valid}, 0);
        exp_sticky = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        // R6: failing-condition clamp still leaves sticky clear after reset.
        run(mk(4'hF, 5'd0, 4'd8, 5'd0, 1'b0), 32'd77, 4'b1111, 1'b1, "R6 never");
        // Random mix of all fields.
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] c;
            logic [31:0] v;
            c = ($urandom % 3 == 0) ? 4'hE : 4'($urandom);
            v = $urandom;
            if ($urandom % 2 == 0) v = 32'($signed(v) >>> ($urandom % 28));
            run(mk(c, 5'($urandom), 4'($urandom), 5'($urandom), 1'($urandom)),
                v, 4'($urandom), 1'($urandom), "random");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule